// File: doc/BRIEF.md
# Atomic Compare-and-Swap Unit

This unit carries out indivisible read-modify-write operations on memory for a processor core. It handles three operations. Test-and-set works on one byte. Compare-and-swap works on one location. Dual compare-and-swap works on two locations. The core presents one request that holds the operation, the operand size, two addresses, two compare values and two update values. The unit then drives a single-master memory port through the whole sequence of reads and writes.

A lock output is raised one cycle before the first access. It stays up until the final access has been acknowledged, so an external arbiter can keep every other master off the bus for the whole sequence. For each compare, the unit subtracts the compare value from the value read from memory, at the operand width, and derives the N, Z, V and C flags from that difference. A location is written only when every compare in the request matches. When a compare fails, no write cycle is issued and the values read from memory are returned in place of the compare values, so the core can reload its compare registers from them.

Operation codes on `req_op`: 0 is test-and-set, 1 is compare-and-swap, 2 is dual compare-and-swap. Size codes on `req_size`: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. All operand values sit right-justified in their 32-bit fields.

Top module: `atomic_rmw_unit`

## Requirements
- R1: For compare-and-swap, `rsp_flags` = {N,Z,V,C} (bit 3 = N) holds the flags of memory minus compare, computed at the operand width. N is the sign bit of the difference. Z means the difference is zero. V is signed overflow. C is a borrow, meaning compare > memory as unsigned values.
- R2: When a compare-and-swap matches, the unit writes the update value to the address once and returns `rsp_ok`=1 with `rsp_val0` equal to the compare value.
- R3: When a compare-and-swap does not match, the unit issues no write, returns `rsp_ok`=0, and sets `rsp_val0` to the value read from memory.
- R4: A dual compare-and-swap reads address 0 and then address 1. Only when both compares match does it write update 0 to address 0 and then update 1 to address 1, returning `rsp_ok`=1.
- R5: When either compare of a dual compare-and-swap fails, the unit writes nothing and returns both memory values on `rsp_val0` and `rsp_val1`. The flags come from the first compare if that compare failed, and from the second compare otherwise.
- R6: A dual compare-and-swap that requests size code 0 is carried out at 16 bits.
- R7: Test-and-set always uses a byte. It reports N = bit 7 of the byte, Z = (byte == 0), V = C = 0, returns the byte on `rsp_val0`, and writes the byte back with bit 7 set.
- R8: `mem_lock` rises one cycle before the first memory request. It stays high during every request of the operation and falls in the cycle `rsp_valid` is high.
- R9: After reset, `req_ready` is 1 and `mem_req`, `mem_lock` and `rsp_valid` are 0.
- R10: Bits of the compare and update inputs above the operand width are ignored. Memory values are compared, returned and written at the operand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_ready | output | 1 | Unit idle, able to take a request |
| req_op | input | 2 | Operation code (0 test-and-set, 1 compare-and-swap, 2 dual) |
| req_size | input | 2 | Size code (0 byte, 1 half, 2 word) |
| req_addr0 | input | AW | First address |
| req_addr1 | input | AW | Second address (dual only) |
| req_cmp0 | input | 32 | First compare value |
| req_cmp1 | input | 32 | Second compare value |
| req_upd0 | input | 32 | First update value |
| req_upd1 | input | 32 | Second update value |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Bus lock for the whole sequence |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | All compares matched (always 1 for test-and-set) |
| rsp_flags | output | 4 | {N,Z,V,C} |
| rsp_val0 | output | 32 | Compare value 0 or observed memory value 0 |
| rsp_val1 | output | 32 | Compare value 1 or observed memory value 1 (dual only, else 0) |

## Verification
The assertions assume that only operation codes 0 to 2 and size codes 0 to 2 are presented. They also assume that `mem_ack` arrives only while `mem_req` is high and that `mem_rdata` is valid in the acknowledge cycle. The bench drives requests only while `req_ready` is high and uses only legal codes. Its memory model acknowledges each request after a rotating latency of one to three cycles, and it drops the acknowledge in the next cycle, so no access is acknowledged twice. The same model checks the lock on every request cycle, and it counts the writes and records their addresses, so a missing write, an extra write or a write in the wrong order is caught at the ports.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr0,
  input  logic [AW-1:0] req_addr1,
  input  logic [31:0]   req_cmp0,
  input  logic [31:0]   req_cmp1,
  input  logic [31:0]   req_upd0,
  input  logic [31:0]   req_upd1,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [3:0]    rsp_flags,
  output logic [31:0]   rsp_val0,
  output logic [31:0]   rsp_val1
);
  localparam logic [1:0] OP_TAS  = 2'd0;
  localparam logic [1:0] OP_DCAS = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LOCK, S_RD0, S_RD1, S_DEC, S_WR0, S_WR1, S_DONE} state_t;
  state_t state;

  logic [1:0]    op_q, sz_q;
  logic [AW-1:0] a0_q, a1_q;
  logic [31:0]   c0_q, c1_q, u0_q, u1_q, m0_q, m1_q;
  logic [3:0]    flags_q;
  logic          ok_q;
  logic [31:0]   v0_q, v1_q;

  function automatic logic [31:0] wmask(input logic [1:0] s);
    case (s)
      2'd0:    wmask = 32'h0000_00FF;
      2'd1:    wmask = 32'h0000_FFFF;
      default: wmask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] cmp_flags(input logic [31:0] m, input logic [31:0] c,
                                           input logic [1:0] s);
    logic [31:0] a, b;
    logic [32:0] d;
    a = (s == 2'd0) ? (m << 24) : (s == 2'd1) ? (m << 16) : m;
    b = (s == 2'd0) ? (c << 24) : (s == 2'd1) ? (c << 16) : c;
    d = {1'b0, a} - {1'b0, b};
    cmp_flags = {d[31], d[31:0] == 32'd0, (a[31] ^ b[31]) & (d[31] ^ a[31]), d[32]};
  endfunction

  logic [1:0] eff_size;
  assign eff_size = (req_op == OP_TAS) ? 2'd0 :
                    (req_op == OP_DCAS && req_size == 2'd0) ? 2'd1 : req_size;

  logic [3:0] f0, f1, dec_flags;
  logic       dec_ok;
  always_comb begin
    f0 = cmp_flags(m0_q, c0_q, sz_q);
    f1 = cmp_flags(m1_q, c1_q, sz_q);
    if (op_q == OP_TAS) begin
      dec_flags = {m0_q[7], m0_q[7:0] == 8'd0, 2'b00};
      dec_ok    = 1'b1;
    end else if (op_q == OP_DCAS) begin
      dec_flags = f0[2] ? f1 : f0;
      dec_ok    = f0[2] & f1[2];
    end else begin
      dec_flags = f0;
      dec_ok    = f0[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q <= '0; sz_q <= '0; a0_q <= '0; a1_q <= '0;
      c0_q <= '0; c1_q <= '0; u0_q <= '0; u1_q <= '0;
      m0_q <= '0; m1_q <= '0;
      flags_q <= '0; ok_q <= 1'b0; v0_q <= '0; v1_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q  <= req_op;
          sz_q  <= eff_size;
          a0_q  <= req_addr0;
          a1_q  <= req_addr1;
          c0_q  <= req_cmp0 & wmask(eff_size);
          c1_q  <= req_cmp1 & wmask(eff_size);
          u0_q  <= req_upd0 & wmask(eff_size);
          u1_q  <= req_upd1 & wmask(eff_size);
          state <= S_LOCK;
        end
        S_LOCK: state <= S_RD0;
        S_RD0: if (mem_ack) begin
          m0_q  <= mem_rdata & wmask(sz_q);
          state <= (op_q == OP_DCAS) ? S_RD1 : S_DEC;
        end
        S_RD1: if (mem_ack) begin
          m1_q  <= mem_rdata & wmask(sz_q);
          state <= S_DEC;
        end
        S_DEC: begin
          flags_q <= dec_flags;
          ok_q    <= dec_ok;
          v0_q    <= (op_q == OP_TAS || !dec_ok) ? m0_q : c0_q;
          v1_q    <= (op_q != OP_DCAS) ? 32'd0 : (dec_ok ? c1_q : m1_q);
          state   <= dec_ok ? S_WR0 : S_DONE;
        end
        S_WR0: if (mem_ack) state <= (op_q == OP_DCAS) ? S_WR1 : S_DONE;
        S_WR1: if (mem_ack) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_RD0) || (state == S_RD1) || (state == S_WR0) || (state == S_WR1);
  assign mem_we    = (state == S_WR0) || (state == S_WR1);
  assign mem_lock  = (state != S_IDLE) && (state != S_DONE);
  assign mem_addr  = (state == S_RD1 || state == S_WR1) ? a1_q : a0_q;
  assign mem_size  = sz_q;
  assign mem_wdata = (state == S_WR1) ? u1_q :
                     (op_q == OP_TAS) ? (m0_q | 32'h80) : u0_q;
  assign rsp_valid = (state == S_DONE);
  assign rsp_ok    = ok_q;
  assign rsp_flags = flags_q;
  assign rsp_val0  = v0_q;
  assign rsp_val1  = v1_q;

  // R8
  lock_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lock) |-> !mem_req);
  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);
  // R8
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> rsp_valid);
  // R3
  no_write_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ok_q);
  // R7
  tas_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && op_q == OP_TAS) |-> mem_wdata[7]);
  // R9
  idle_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_lock && !mem_req));
  // R5
  dual_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok && op_q == OP_DCAS) |-> (rsp_val0 == m0_q && rsp_val1 == m1_q));
endmodule

// File: tb/atomic_rmw_unit_bench.sv
`timescale 1ns/1ps
module atomic_rmw_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0, req_size = '0;
  logic [15:0] req_addr0 = '0, req_addr1 = '0;
  logic [31:0] req_cmp0 = '0, req_cmp1 = '0, req_upd0 = '0, req_upd1 = '0;
  logic mem_req, mem_we, mem_lock, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic rsp_valid, rsp_ok;
  logic [3:0] rsp_flags;
  logic [31:0] rsp_val0, rsp_val1;

  atomic_rmw_unit #(.AW(16)) u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_addr0(req_addr0), .req_addr1(req_addr1),
    .req_cmp0(req_cmp0), .req_cmp1(req_cmp1), .req_upd0(req_upd0), .req_upd1(req_upd1),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_flags(rsp_flags),
    .rsp_val0(rsp_val0), .rsp_val1(rsp_val1));

  int checks = 0, fails = 0;
  logic [31:0] mem [16];
  int writes, lock_bad, wait_cnt, lat;
  logic [15:0] wr_at [4];
  logic lock_prev;
  logic r_seen, r_ok, r_lock;
  logic [3:0] r_flags;
  logic [31:0] r_v0, r_v1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
  endfunction

  function automatic logic [3:0] ref_flags(input logic [31:0] m, input logic [31:0] c, input int w);
    logic [31:0] mm, cc, d, t;
    mm = m & mk(w); cc = c & mk(w); d = (mm - cc) & mk(w);
    t = (mm ^ cc) & (mm ^ d);
    return {d[w-1], d == 32'd0, t[w-1], cc > mm};
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic [15:0] a0,
                        input logic [15:0] a1, input logic [31:0] c0, input logic [31:0] c1,
                        input logic [31:0] u0, input logic [31:0] u1);
    int guard;
    @(negedge clk);
    req_op = op; req_size = sz; req_addr0 = a0; req_addr1 = a1;
    req_cmp0 = c0; req_cmp1 = c1; req_upd0 = u0; req_upd1 = u1;
    req_valid = 1'b1; writes = 0; lock_bad = 0; lock_prev = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 300) begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (!(mem_lock && lock_prev)) lock_bad++;
        if (wait_cnt == 0) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr[3:0]] = mem_wdata;
            if (writes < 4) wr_at[writes] = mem_addr;
            writes++;
          end else mem_rdata = mem[mem_addr[3:0]];
          wait_cnt = lat;
          lat = (lat == 2) ? 0 : lat + 1;
        end else wait_cnt--;
      end
      lock_prev = mem_lock;
      @(negedge clk);
      guard++;
    end
    mem_ack = 1'b0;
    r_seen = rsp_valid; r_ok = rsp_ok; r_flags = rsp_flags;
    r_v0 = rsp_val0; r_v1 = rsp_val1; r_lock = mem_lock;
  endtask

  task automatic lock_checks();
    chk("R8", "response seen", 32'(r_seen), 32'd1);
    chk("R8", "lock ahead and held on every request", lock_bad, 0);
    chk("R8", "lock low at response", 32'(r_lock), 32'd0);
  endtask

  task automatic do_cas(input string req, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] mv, input logic [31:0] c, input logic [31:0] u);
    int w;
    logic hit;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mem[a[3:0]] = mv;
    hit = ((mv & mk(w)) == (c & mk(w)));
    run_op(2'd1, sz, a, 16'd0, c, 32'd0, u, 32'd0);
    lock_checks();
    chk({req, " R1"}, "flags", 32'(r_flags), 32'(ref_flags(mv, c, w)));
    chk(req, "ok", 32'(r_ok), 32'(hit));
    chk(req, "val0", r_v0, hit ? (c & mk(w)) : (mv & mk(w)));
    chk(req, "write count", writes, hit ? 1 : 0);
    chk(req, "memory", mem[a[3:0]], hit ? (u & mk(w)) : mv);
  endtask

  task automatic do_dcas(input string req, input logic [1:0] sz, input logic [15:0] a0, input logic [15:0] a1,
                         input logic [31:0] m0, input logic [31:0] m1, input logic [31:0] c0,
                         input logic [31:0] c1, input logic [31:0] u0, input logic [31:0] u1);
    int w;
    logic h0, h1, ok;
    w = (sz == 2'd2) ? 32 : 16;
    mem[a0[3:0]] = m0; mem[a1[3:0]] = m1;
    h0 = ((m0 & mk(w)) == (c0 & mk(w)));
    h1 = ((m1 & mk(w)) == (c1 & mk(w)));
    ok = h0 && h1;
    run_op(2'd2, sz, a0, a1, c0, c1, u0, u1);
    lock_checks();
    chk(req, "flags", 32'(r_flags), 32'(h0 ? ref_flags(m1, c1, w) : ref_flags(m0, c0, w)));
    chk(req, "ok", 32'(r_ok), 32'(ok));
    chk(req, "val0", r_v0, ok ? (c0 & mk(w)) : (m0 & mk(w)));
    chk(req, "val1", r_v1, ok ? (c1 & mk(w)) : (m1 & mk(w)));
    chk(req, "write count", writes, ok ? 2 : 0);
    chk(req, "memory 0", mem[a0[3:0]], ok ? (u0 & mk(w)) : m0);
    chk(req, "memory 1", mem[a1[3:0]], ok ? (u1 & mk(w)) : m1);
    if (ok) begin
      chk(req, "first write address", 32'(wr_at[0]), 32'(a0));
      chk(req, "second write address", 32'(wr_at[1]), 32'(a1));
    end
  endtask

  task automatic do_tas(input logic [15:0] a, input logic [31:0] mv);
    logic [7:0] b;
    b = mv[7:0];
    mem[a[3:0]] = mv;
    run_op(2'd0, 2'd2, a, 16'd0, 32'hDEAD_BEEF, 32'd0, 32'h1234_5678, 32'd0);
    lock_checks();
    chk("R7", "flags", 32'(r_flags), 32'({b[7], b == 8'd0, 2'b00}));
    chk("R7", "ok", 32'(r_ok), 32'd1);
    chk("R7", "val0", r_v0, 32'(b));
    chk("R7", "write count", writes, 1);
    chk("R7", "memory", mem[a[3:0]], 32'(b | 8'h80));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "req_ready", 32'(req_ready), 32'd1);
    chk("R9", "mem_req", 32'(mem_req), 32'd0);
    chk("R9", "mem_lock", 32'(mem_lock), 32'd0);
    chk("R9", "rsp_valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_cas_byte_hit_upper_ignored();
    do_cas("R2 R10", 2'd0, 16'd3, 32'h0000_005A, 32'hFFFF_FF5A, 32'hAB12_3433);
  endtask
  task automatic t_cas_half_miss_borrow();
    do_cas("R3", 2'd1, 16'd4, 32'h0000_1234, 32'h0000_1235, 32'h0000_9999);
  endtask
  task automatic t_cas_word_overflow();
    do_cas("R3 R1", 2'd2, 16'd5, 32'h8000_0000, 32'h0000_0001, 32'h0);
  endtask
  task automatic t_cas_byte_signed();
    do_cas("R1", 2'd0, 16'd6, 32'h0000_007F, 32'h0000_0080, 32'h11);
  endtask
  task automatic t_cas_word_hit();
    do_cas("R2", 2'd2, 16'd7, 32'hCAFE_F00D, 32'hCAFE_F00D, 32'h0BAD_C0DE);
  endtask
  task automatic t_dcas_hit();
    do_dcas("R4", 2'd2, 16'd8, 16'd9, 32'h1111_2222, 32'h3333_4444,
            32'h1111_2222, 32'h3333_4444, 32'hAAAA_0001, 32'hBBBB_0002);
  endtask
  task automatic t_dcas_miss_first();
    do_dcas("R5", 2'd1, 16'd10, 16'd11, 32'h0000_0010, 32'h0000_0020,
            32'h0000_0030, 32'h0000_0020, 32'h1, 32'h2);
  endtask
  task automatic t_dcas_miss_second();
    do_dcas("R5", 2'd2, 16'd12, 16'd13, 32'h0000_0050, 32'h8000_0000,
            32'h0000_0050, 32'h0000_0001, 32'h5, 32'h6);
  endtask
  task automatic t_dcas_byte_promoted();
    do_dcas("R6", 2'd0, 16'd14, 16'd15, 32'h0000_5634, 32'h0000_0001,
            32'h0000_7734, 32'h0000_0001, 32'h7, 32'h8);
  endtask
  task automatic t_tas_zero();
    do_tas(16'd1, 32'h0000_0000);
  endtask
  task automatic t_tas_set();
    do_tas(16'd2, 32'h1234_56C3);
  endtask

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'd0;
    writes = 0; lock_bad = 0; wait_cnt = 0; lat = 1; lock_prev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cas_byte_hit_upper_ignored();
    t_cas_half_miss_borrow();
    t_cas_word_overflow();
    t_cas_byte_signed();
    t_cas_word_hit();
    t_dcas_hit();
    t_dcas_miss_first();
    t_dcas_miss_second();
    t_dcas_byte_promoted();
    t_tas_zero();
    t_tas_set();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
      $finish;
    end
  end
endmodule